// File: doc/BRIEF.md
# Dual-Line Interrupt Event Aggregator

This block collects interrupt events for an Ethernet MAC and turns them into two level-sensitive request lines. A 32-bit sticky event register latches one-cycle pulses from the surrounding hardware. A 32-bit enable register, owned by software, selects which latched events may raise a request. The precision-timer event sits alone on one line. The sixteen MAC events in the upper half-word (heartbeat, babble on either direction, graceful stop, frame and buffer completion on both directions, management interface, bus error, late collision, retry limit, underrun, payload error, wakeup, timestamp available) are ORed onto the other line.

Software uses a word-wide register port to reach both registers. Writing ones to the event word acknowledges those events. The enable word is written as a whole. Both request lines are registered, and each one is computed from the register values that take effect on the same clock edge. A write, a hardware pulse or an enable change therefore shows on the lines in the same cycle that the registers change.

Top module: `irq_event_agg`

## Requirements
- R1: A synchronous reset clears the event word and the enable word, and drives both request lines low.
- R2: A pulse on `evt_pulse_i` bit n sets event bit n on the next clock edge. The bit stays set after the pulse ends, and setting further bits leaves earlier bits set.
- R3: A write to the event word (address 0) clears each event bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: When a hardware pulse and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R5: Event bits 14 down to 0 never set, always read as 0, and never raise either line, even with every enable bit set.
- R6: `irq_timer_o` is high exactly when event bit 15 and enable bit 15 are both 1.
- R7: `irq_mac_o` is high exactly when some bit in 31 down to 16 is 1 in both the event word and the enable word.
- R8: Bit 15 has no effect on `irq_mac_o`, and bits 31 down to 16 have no effect on `irq_timer_o`.
- R9: A write to the enable word (address 1) stores all 32 data bits, which read back unchanged.
- R10: A read asserted in one cycle returns the addressed word on `reg_rdata_o` after the next clock edge. Addresses other than 0 and 1 read as 0, and writes to them change nothing.
- R11: Both lines take their new value on the same clock edge that updates the event or enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse_i | input | 32 | One-cycle hardware event pulses, one per event bit |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Word address: 0 event word, 1 enable word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| irq_mac_o | output | 1 | MAC group request line (line 0) |
| irq_timer_o | output | 1 | Precision-timer request line (line 1) |

## Verification
A wrong event bit shows at the port in two ways. It appears in the next read of the event word. If its enable bit is set, it also appears on the request line for its group after the same edge that corrupted it. A wrong enable bit shows in the same ways through a read of the enable word. Line steering faults are caught by enabling one group at a time and pulsing events in the other group. A fault that reversed the priority between set and clear would leave an acknowledged bit missing in the read that follows the collision.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_evt_store.sv
module irq_evt_store #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LIVE_VEC = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] ev_o,
  output logic [DATA_W-1:0] ev_next_o
);
  logic [DATA_W-1:0] ev_q;
  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    clr_vec   = clr_en_i ? clr_i : '0;
    ev_next_o = ((ev_q & ~clr_vec) | set_i) & LIVE_VEC;
  end

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_next_o;
  end

  assign ev_o = ev_q;

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_q & ~LIVE_VEC) == '0);

  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ((set_i & LIVE_VEC) != '0) |=>
      ((ev_q & $past(set_i & LIVE_VEC)) == $past(set_i & LIVE_VEC)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && set_i == '0) |=> ((ev_q & $past(clr_i)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_en_i && (set_i & clr_i & LIVE_VEC) != '0) |=>
      ((ev_q & $past(set_i & clr_i & LIVE_VEC)) == $past(set_i & clr_i & LIVE_VEC)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mask_next_o
);
  logic [DATA_W-1:0] mask_q;

  always_comb mask_next_o = wr_en_i ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next_o;
  end

  assign mask_o = mask_q;

  p_mask_store_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 2,
  parameter logic [NUM_LINES*DATA_W-1:0] LINE_SEL = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    ev_next_i,
  input  logic [DATA_W-1:0]    mask_next_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [DATA_W-1:0] pend;

  always_comb pend = ev_next_i & mask_next_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic line_q;
    always_ff @(posedge clk) begin
      if (rst) line_q <= 1'b0;
      else     line_q <= |(pend & LINE_SEL[g*DATA_W +: DATA_W]);
    end
    assign irq_o[g] = line_q;
  end
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
  import irq_agg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int TIMER_BIT = 15,
  parameter int GROUP_LO  = 16,
  parameter int EVT_ADDR  = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt_pulse_i,
  input  logic              reg_wr_en_i,
  input  logic              reg_rd_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_mac_o,
  output logic              irq_timer_o
);
  localparam logic [DATA_W-1:0] TIMER_VEC = DATA_W'(1) << TIMER_BIT;
  localparam logic [DATA_W-1:0] GROUP_VEC = {DATA_W{1'b1}} << GROUP_LO;
  localparam logic [DATA_W-1:0] LIVE_VEC  = TIMER_VEC | GROUP_VEC;
  localparam int NUM_LINES = 2;

  reg_sel_e sel;
  logic [DATA_W-1:0] ev_q, ev_next, mask_q, mask_next, rdata_q;
  logic [NUM_LINES-1:0] irq;

  always_comb begin
    if (reg_addr_i == ADDR_W'(EVT_ADDR))       sel = SEL_EVENT;
    else if (reg_addr_i == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
    else                                       sel = SEL_NONE;
  end

  irq_evt_store #(.DATA_W(DATA_W), .LIVE_VEC(LIVE_VEC)) u_store (
    .clk(clk), .rst(rst), .set_i(evt_pulse_i),
    .clr_en_i(reg_wr_en_i && sel == SEL_EVENT), .clr_i(reg_wdata_i),
    .ev_o(ev_q), .ev_next_o(ev_next)
  );

  irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .wr_en_i(reg_wr_en_i && sel == SEL_MASK),
    .wdata_i(reg_wdata_i), .mask_o(mask_q), .mask_next_o(mask_next)
  );

  irq_line_drv #(
    .DATA_W(DATA_W), .NUM_LINES(NUM_LINES),
    .LINE_SEL({TIMER_VEC, GROUP_VEC})
  ) u_lines (
    .clk(clk), .rst(rst), .ev_next_i(ev_next), .mask_next_i(mask_next),
    .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd_en_i) begin
      case (sel)
        SEL_EVENT: rdata_q <= ev_q;
        SEL_MASK:  rdata_q <= mask_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_mac_o   = irq[0];
  assign irq_timer_o = irq[1];

  p_timer_line_r6: assert property (@(posedge clk) disable iff (rst)
    irq_timer_o == (ev_q[TIMER_BIT] & mask_q[TIMER_BIT]));

  p_mac_line_r7: assert property (@(posedge clk) disable iff (rst)
    irq_mac_o == ((ev_q & mask_q & GROUP_VEC) != '0));

  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en_i && sel == SEL_NONE) |=> (reg_rdata_o == '0));
endmodule

// File: tb/tb_irq_event_agg.sv
module tb_irq_event_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_pulse_i = '0;
  logic        reg_wr_en_i = 1'b0;
  logic        reg_rd_en_i = 1'b0;
  logic [1:0]  reg_addr_i  = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_mac_o, irq_timer_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_event_agg dut (
    .clk(clk), .rst(rst), .evt_pulse_i(evt_pulse_i),
    .reg_wr_en_i(reg_wr_en_i), .reg_rd_en_i(reg_rd_en_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_mac_o(irq_mac_o), .irq_timer_o(irq_timer_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en_i = 1'b1; reg_addr_i = a;
    @(negedge clk);
    reg_rd_en_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt_pulse_i = v;
    @(negedge clk);
    evt_pulse_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_mac", {31'd0, irq_mac_o}, 32'd0);
    chk("R1 irq_timer", {31'd0, irq_timer_o}, 32'd0);
    rd(2'd0, d); chk("R1 event", d, 32'd0);
    rd(2'd1, d); chk("R1 mask", d, 32'd0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(32'h0004_0000);
    rd(2'd0, d); chk("R2 set", d, 32'h0004_0000);
    pulse(32'h8000_0000);
    rd(2'd0, d); chk("R2 sticky", d, 32'h8004_0000);
    chk("R7 masked off", {31'd0, irq_mac_o}, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(2'd0, 32'h0004_0000);
    rd(2'd0, d); chk("R3 clear one", d, 32'h8000_0000);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk("R3 zero no effect", d, 32'h8000_0000);
    wr(2'd0, 32'h8000_0000);
    rd(2'd0, d); chk("R3 clear last", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    evt_pulse_i = 32'h0010_0000;
    reg_wr_en_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0010_0000;
    @(negedge clk);
    evt_pulse_i = '0; reg_wr_en_i = 1'b0;
    rd(2'd0, d); chk("R4 set wins", d, 32'h0010_0000);
    wr(2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    pulse(32'h0000_7FFF);
    chk("R5 no mac", {31'd0, irq_mac_o}, 32'd0);
    chk("R5 no timer", {31'd0, irq_timer_o}, 32'd0);
    rd(2'd0, d); chk("R5 reads zero", d, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_timer();
    wr(2'd1, 32'h0000_8000);
    pulse(32'h0000_8000);
    chk("R6 timer high", {31'd0, irq_timer_o}, 32'd1);
    chk("R8 mac unaffected", {31'd0, irq_mac_o}, 32'd0);
    wr(2'd1, 32'h0);
    chk("R6 masked low", {31'd0, irq_timer_o}, 32'd0);
    wr(2'd1, 32'hFFFF_8000 & 32'h0000_8000);
    chk("R6 unmask high", {31'd0, irq_timer_o}, 32'd1);
    wr(2'd0, 32'h0000_8000);
    chk("R6 cleared low", {31'd0, irq_timer_o}, 32'd0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_mac();
    wr(2'd1, 32'h0001_0000);
    pulse(32'h0002_0000);
    chk("R7 other bit masked", {31'd0, irq_mac_o}, 32'd0);
    @(negedge clk);
    evt_pulse_i = 32'h0001_0000;
    @(negedge clk);
    evt_pulse_i = '0;
    chk("R11 same edge mac", {31'd0, irq_mac_o}, 32'd1);
    chk("R8 timer unaffected", {31'd0, irq_timer_o}, 32'd0);
    wr(2'd1, 32'hFFFF_0000);
    chk("R7 still high", {31'd0, irq_mac_o}, 32'd1);
    wr(2'd0, 32'h0001_0000);
    chk("R7 other enabled bit", {31'd0, irq_mac_o}, 32'd1);
    wr(2'd0, 32'h0002_0000);
    chk("R11 same edge clear", {31'd0, irq_mac_o}, 32'd0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_mask_map();
    logic [31:0] d;
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); chk("R9 readback", d, 32'h1234_5678);
    rd(2'd2, d); chk("R10 unmapped read", d, 32'h0);
    pulse(32'h0080_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 mask untouched", d, 32'h1234_5678);
    rd(2'd0, d); chk("R10 event untouched", d, 32'h0080_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sticky();
    t_clear();
    t_set_wins();
    t_reserved();
    t_timer();
    t_mac();
    t_mask_map();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule